// File: doc/BRIEF.md
# DCC Track Signal Generator

This block produces a continuous model-railway DCC track waveform from short command packets. Every bit is a high phase followed by a low phase of equal length. A one bit uses short phases and a zero bit uses long phases. Both phase lengths are derived from the input clock frequency parameter.

A host hands over a packet of one to five data bytes, together with a repeat count, on a valid/ready load port. The block adds an XOR checksum byte and builds the whole frame itself. The frame is a run of preamble ones, a zero start bit, and each byte sent most significant bit first. A zero separator follows every byte except the checksum, which is closed by a one end bit. One trailing zero follows the end bit.

A loaded packet always waits for the current frame to finish before it goes out. It is then transmitted the requested number of extra times. Whenever nothing is queued, idle packets fill the line, so the track never falls silent.

Top module: `dcc_track_gen`

## Requirements
- R1: While reset is high, `track_out` is low. After reset, `ld_ready` is high.
- R2: Each bit is `track_out` high then low for equal phases. The phase is ONE_HALF_US microseconds for a one and ZERO_HALF_US microseconds for a zero, rounded down to whole cycles of CLK_HZ.
- R3: Every frame opens with exactly PRE_BITS one bits, followed by a single zero start bit.
- R4: Frame bytes go out most significant bit first, in ascending byte order. `ld_data[8i+7:8i]` is byte i. A zero separator bit follows each byte except the last.
- R5: The last byte of a frame is followed by a one end bit and then by exactly one zero bit before the next preamble.
- R6: The last byte of every frame is the XOR of all the bytes before it.
- R7: With nothing loaded and no repeats left, each frame is the idle packet 0xFF, 0x00, checksum 0xFF.
- R8: A load with `ld_len` of 0 or above 5 completes its handshake, is discarded, and never appears on the track. `ld_ready` stays high afterwards.
- R9: `ld_ready` is low from the cycle after an accepted load until that packet has started and its repeats are used up.
- R10: A packet loaded with repeat count N goes out N+1 times back to back, then the next loaded packet or idle follows.
- R11: A packet loaded while a frame is on the track does not disturb that frame. It starts only at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request |
| ld_len | input | 4 | Number of data bytes in the request (valid 1..5) |
| ld_data | input | 40 | Data bytes, byte i at bits 8i+7..8i, byte 0 sent first |
| ld_rep | input | 4 | Extra transmissions after the first |
| ld_ready | output | 1 | Load accepted when high together with `ld_valid` |
| track_out | output | 1 | Registered track waveform |

## Verification
A scoreboard decodes the waveform into bits by timing each phase, then into frames, and compares each non-idle frame with the packets the driver queued. Several patterns are used. A three-byte packet with mixed bit values tests bit order and the checksum. A single byte repeated three times tests repeat counting and the ready stall. A full five-byte packet tests the longest frame, and a two-byte packet loaded right behind it tests back-to-back hand-over without an idle gap. Lengths of zero and six must leave no trace on the track. A load made part-way through an idle frame must let that idle frame finish intact before the new packet starts.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [2:0] {
    S_PRE,
    S_START,
    S_DATA,
    S_SEP,
    S_EXTRA
  } seq_st_t;

  localparam logic [23:0] IDLE_BYTES = 24'hFF_00_FF;  // byte0=FF, byte1=00, byte2=FF
  localparam int          IDLE_COUNT = 3;

endpackage

// File: rtl/dcc_bit_timer.sv
module dcc_bit_timer #(
  parameter int unsigned HALF1 = 4640,
  parameter int unsigned HALF0 = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_val,
  output logic take,
  output logic track_q
);

  localparam int unsigned HMAX = (HALF0 > HALF1) ? HALF0 : HALF1;
  localparam int CW = $clog2(HMAX + 1);

  logic          running;
  logic          cur_bit;
  logic [CW-1:0] cnt;

  assign take = !running || (!track_q && cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cur_bit <= 1'b0;
      cnt     <= '0;
      track_q <= 1'b0;
    end else if (take) begin
      running <= 1'b1;
      cur_bit <= bit_val;
      cnt     <= bit_val ? CW'(HALF1 - 1) : CW'(HALF0 - 1);
      track_q <= 1'b1;
    end else if (cnt == '0) begin
      cnt     <= cur_bit ? CW'(HALF1 - 1) : CW'(HALF0 - 1);
      track_q <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2: a phase keeps its level until its counter runs out
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != '0) |=> $stable(track_q));

  // R2: every bit begins with the high phase
  p_bit_starts_high_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> track_q);

endmodule

// File: rtl/dcc_frame_seq.sv
module dcc_frame_seq
  import dcc_pkg::*;
#(
  parameter int PRE_BITS    = 16,
  parameter int FRAME_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          take,
  input  logic [FRAME_BYTES*8-1:0]      frame,
  input  logic [$clog2(FRAME_BYTES+1)-1:0] frame_cnt,
  output logic                          bit_val,
  output logic                          adv
);

  localparam int PCW = $clog2(PRE_BITS);
  localparam int FCW = $clog2(FRAME_BYTES + 1);

  seq_st_t        st;
  logic [PCW-1:0] pre_cnt;
  logic [FCW-1:0] byte_idx;
  logic [2:0]     bit_idx;
  logic [7:0]     cur_byte;
  logic           last;

  assign cur_byte = frame[8*int'(byte_idx) +: 8];
  assign last     = (byte_idx == frame_cnt - 1'b1);
  assign adv      = take && (st == S_EXTRA);

  always_comb begin
    case (st)
      S_PRE:   bit_val = 1'b1;
      S_START: bit_val = 1'b0;
      S_DATA:  bit_val = cur_byte[3'd7 - bit_idx];
      S_SEP:   bit_val = last;
      default: bit_val = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_PRE;
      pre_cnt  <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (take) begin
      case (st)
        S_PRE: begin
          if (pre_cnt == PCW'(PRE_BITS - 1)) begin
            st      <= S_START;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        S_START: begin
          st       <= S_DATA;
          byte_idx <= '0;
          bit_idx  <= '0;
        end
        S_DATA: begin
          if (bit_idx == 3'd7) st <= S_SEP;
          bit_idx <= bit_idx + 1'b1;
        end
        S_SEP: begin
          if (last) begin
            st <= S_EXTRA;
          end else begin
            st       <= S_DATA;
            byte_idx <= byte_idx + 1'b1;
            bit_idx  <= '0;
          end
        end
        default: begin
          st      <= S_PRE;
          pre_cnt <= '0;
        end
      endcase
    end
  end

  // R3: the preamble is followed by the start bit
  p_start_after_pre_r3: assert property (@(posedge clk) disable iff (rst)
    (take && st == S_PRE && pre_cnt == PCW'(PRE_BITS - 1)) |=> (st == S_START));

  // R5: after the end bit comes the single trailing zero
  p_extra_after_end_r5: assert property (@(posedge clk) disable iff (rst)
    (take && st == S_SEP && last) |=> (st == S_EXTRA));

endmodule

// File: rtl/dcc_load_ctrl.sv
module dcc_load_ctrl
  import dcc_pkg::*;
#(
  parameter int MAX_DATA = 5,
  parameter int REP_W    = 4,
  parameter int LEN_W    = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             ld_valid,
  input  logic [LEN_W-1:0]                 ld_len,
  input  logic [MAX_DATA*8-1:0]            ld_data,
  input  logic [REP_W-1:0]                 ld_rep,
  output logic                             ld_ready,
  input  logic                             adv,
  output logic [(MAX_DATA+1)*8-1:0]        frame,
  output logic [$clog2(MAX_DATA+2)-1:0]    frame_cnt
);

  localparam int FRAME_BYTES = MAX_DATA + 1;
  localparam int FW  = FRAME_BYTES * 8;
  localparam int FCW = $clog2(FRAME_BYTES + 1);
  localparam logic [FW-1:0] IDLE_FRAME = FW'(IDLE_BYTES);

  logic             pend_v;
  logic [FW-1:0]    pend_frame;
  logic [FCW-1:0]   pend_cnt;
  logic [REP_W-1:0] pend_rep;
  logic [REP_W-1:0] rem;

  logic             len_ok;
  logic             accept;
  logic [7:0]       chk;
  logic [FW-1:0]    data_pad;
  logic [FW-1:0]    built;

  assign len_ok   = (ld_len != '0) && (ld_len <= LEN_W'(MAX_DATA));
  assign ld_ready = !pend_v && (rem == '0);
  assign accept   = ld_valid && ld_ready;
  assign data_pad = {8'h00, ld_data};

  always_comb begin
    chk   = 8'h00;
    built = '0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(ld_len)) chk = chk ^ ld_data[8*i +: 8];
    end
    for (int j = 0; j < FRAME_BYTES; j++) begin
      if (j < int'(ld_len))       built[8*j +: 8] = data_pad[8*j +: 8];
      else if (j == int'(ld_len)) built[8*j +: 8] = chk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_frame <= '0;
      pend_cnt   <= '0;
      pend_rep   <= '0;
    end else if (accept && len_ok) begin
      pend_v     <= 1'b1;
      pend_frame <= built;
      pend_cnt   <= FCW'(ld_len) + 1'b1;
      pend_rep   <= ld_rep;
    end else if (adv) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame     <= IDLE_FRAME;
      frame_cnt <= FCW'(IDLE_COUNT);
      rem       <= '0;
    end else if (adv) begin
      if (pend_v) begin
        frame     <= pend_frame;
        frame_cnt <= pend_cnt;
        rem       <= pend_rep;
      end else if (rem != '0) begin
        rem <= rem - 1'b1;
      end else begin
        frame     <= IDLE_FRAME;
        frame_cnt <= FCW'(IDLE_COUNT);
      end
    end
  end

  // R9: a good load closes the port
  p_busy_after_load_r9: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && len_ok) |=> !ld_ready);

  // R8: a bad length leaves the port open
  p_bad_len_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && !len_ok) |=> ld_ready);

  // R10: starting a packet arms its repeat count
  p_repeat_armed_r10: assert property (@(posedge clk) disable iff (rst)
    (adv && pend_v) |=> (rem == $past(pend_rep)));

  // R7: nothing to send means idle
  p_idle_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && !pend_v && rem == '0) |=> (frame == IDLE_FRAME));

endmodule

// File: rtl/dcc_track_gen.sv
module dcc_track_gen #(
  parameter int unsigned CLK_HZ       = 80_000_000,
  parameter int unsigned ONE_HALF_US  = 58,
  parameter int unsigned ZERO_HALF_US = 100,
  parameter int          PRE_BITS     = 16,
  parameter int          MAX_DATA     = 5,
  parameter int          REP_W        = 4,
  parameter int          LEN_W        = $clog2(MAX_DATA + 1) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [LEN_W-1:0]      ld_len,
  input  logic [MAX_DATA*8-1:0] ld_data,
  input  logic [REP_W-1:0]      ld_rep,
  output logic                  ld_ready,
  output logic                  track_out
);

  localparam int FRAME_BYTES = MAX_DATA + 1;
  localparam int FCW = $clog2(FRAME_BYTES + 1);
  localparam longint unsigned HALF1_L = (longint'(CLK_HZ) * longint'(ONE_HALF_US)) / 64'd1_000_000;
  localparam longint unsigned HALF0_L = (longint'(CLK_HZ) * longint'(ZERO_HALF_US)) / 64'd1_000_000;
  localparam int unsigned HALF1 = int'(HALF1_L);
  localparam int unsigned HALF0 = int'(HALF0_L);

  logic                     take;
  logic                     bit_val;
  logic                     adv;
  logic [FRAME_BYTES*8-1:0] frame;
  logic [FCW-1:0]           frame_cnt;

  dcc_load_ctrl #(
    .MAX_DATA (MAX_DATA),
    .REP_W    (REP_W),
    .LEN_W    (LEN_W)
  ) u_load (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_len    (ld_len),
    .ld_data   (ld_data),
    .ld_rep    (ld_rep),
    .ld_ready  (ld_ready),
    .adv       (adv),
    .frame     (frame),
    .frame_cnt (frame_cnt)
  );

  dcc_frame_seq #(
    .PRE_BITS    (PRE_BITS),
    .FRAME_BYTES (FRAME_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .frame     (frame),
    .frame_cnt (frame_cnt),
    .bit_val   (bit_val),
    .adv       (adv)
  );

  dcc_bit_timer #(
    .HALF1 (HALF1),
    .HALF0 (HALF0)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .bit_val (bit_val),
    .take    (take),
    .track_q (track_out)
  );

  // R1: the line is quiet in the cycle after a reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !track_out);

endmodule

// File: tb/dcc_track_gen_tb.sv
module dcc_track_gen_tb;

  localparam int P   = 10;
  localparam int H1  = 58;
  localparam int H0  = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [3:0]  ld_len = '0;
  logic [39:0] ld_data = '0;
  logic [3:0]  ld_rep = '0;
  logic        ld_ready;
  logic        track_out;

  always #4 clk = ~clk;

  dcc_track_gen #(
    .CLK_HZ   (1_000_000),
    .PRE_BITS (P)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_len    (ld_len),
    .ld_data   (ld_data),
    .ld_rep    (ld_rep),
    .ld_ready  (ld_ready),
    .track_out (track_out)
  );

  int checks = 0;
  int fails  = 0;
  int idle_frames = 0;
  int data_frames = 0;
  bit done = 0;

  int          exp_len[$];
  logic [39:0] exp_dat[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  int       dstate = 0;  // 0 hunt preamble, 1 bytes, 2 trailing zero
  int       ones = 0;
  int       nbits = 0;
  int       nbytes = 0;
  logic [7:0] cur = '0;
  logic [7:0] fb [0:7];

  task automatic end_frame;
    logic [7:0] x;
    int dl;
    logic [39:0] ed;
    x = 8'h00;
    for (int i = 0; i < nbytes; i++) x = x ^ fb[i];
    chk(x == 8'h00, "R6", "checksum residue", x, 0);
    if (nbytes == 3 && fb[0] == 8'hFF && fb[1] == 8'h00 && fb[2] == 8'hFF) begin
      idle_frames++;
    end else begin
      data_frames++;
      if (exp_len.size() == 0) begin
        chk(1'b0, "R8", "unexpected data packet length", nbytes - 1, 0);
      end else begin
        dl = exp_len.pop_front();
        ed = exp_dat.pop_front();
        chk(nbytes - 1 == dl, "R10", "packet length", nbytes - 1, dl);
        for (int i = 0; i < dl && i < nbytes; i++)
          chk(fb[i] == ed[8*i +: 8], "R4", "packet byte", fb[i], ed[8*i +: 8]);
      end
    end
  endtask

  task automatic got_bit(input int h, input int l);
    bit b;
    bit ok;
    ok = (h == H1 && l == H1) || (h == H0 && l == H0);
    chk(ok, "R2", "phase lengths high*1000+low", h * 1000 + l, (h == H1) ? H1 * 1000 + H1 : H0 * 1000 + H0);
    b = (h == H1);
    case (dstate)
      0: begin
        if (b) ones++;
        else begin
          chk(ones == P, "R3", "preamble ones", ones, P);
          nbytes = 0; nbits = 0; dstate = 1;
        end
      end
      1: begin
        if (nbits < 8) begin
          cur = {cur[6:0], b};
          nbits++;
        end else begin
          fb[nbytes] = cur;
          nbytes++;
          nbits = 0;
          if (b) begin
            end_frame();
            dstate = 2;
          end else if (nbytes >= 7) begin
            chk(1'b0, "R4", "frame too long", nbytes, 6);
            dstate = 0; ones = 0;
          end
        end
      end
      default: begin
        chk(b == 1'b0, "R5", "trailing bit", b, 0);
        dstate = 0; ones = 0;
      end
    endcase
  endtask

  initial begin
    bit prev;
    int hcnt;
    int lcnt;
    prev = 0; hcnt = 0; lcnt = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev = 0; hcnt = 0; lcnt = 0;
      end else begin
        if (track_out && !prev) begin
          if (hcnt > 0) got_bit(hcnt, lcnt);
          hcnt = 1; lcnt = 0;
        end else if (track_out) hcnt++;
        else lcnt++;
        prev = track_out;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic load(input int len, input logic [39:0] d, input int rep);
    bit good;
    good = (len >= 1 && len <= 5);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1;
    ld_len   = 4'(len);
    ld_data  = d;
    ld_rep   = 4'(rep);
    if (good) begin
      for (int k = 0; k <= rep; k++) begin
        exp_len.push_back(len);
        exp_dat.push_back(d);
      end
    end
    @(posedge clk);
    #1 ld_valid = 1'b0;
    @(negedge clk);
    if (good) chk(ld_ready == 1'b0, "R9", "ready after accepted load", ld_ready, 0);
    else      chk(ld_ready == 1'b1, "R8", "ready after rejected load", ld_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int snap_total;
    int snap_idle;
    repeat (3) @(negedge clk);
    chk(track_out == 1'b0, "R1", "track during reset", track_out, 0);
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(ld_ready == 1'b1, "R1", "ready after reset", ld_ready, 1);

    while (idle_frames < 2) @(negedge clk);
    chk(data_frames == 0, "R7", "data frames with nothing loaded", data_frames, 0);
    chk(idle_frames >= 2, "R7", "idle frames seen", idle_frames, 2);

    // load part-way through an idle frame
    repeat (2000) @(negedge clk);
    snap_total = idle_frames + data_frames;
    snap_idle  = idle_frames;
    load(3, 40'h00_0007_813C, 0);
    while (idle_frames + data_frames == snap_total) @(negedge clk);
    chk(idle_frames == snap_idle + 1, "R11", "frame in flight finished as idle", idle_frames, snap_idle + 1);

    load(1, 40'h00_0000_00A5, 2);
    while (data_frames < 2) @(negedge clk);
    chk(ld_ready == 1'b0, "R10", "ready while repeats remain", ld_ready, 0);

    load(0, 40'h00_0000_0011, 0);
    load(6, 40'h55_4433_2211, 0);

    load(5, 40'h9A_7856_3412, 1);
    load(2, 40'h00_0000_01FE, 0);

    while (exp_len.size() > 0) @(negedge clk);
    snap_idle = idle_frames;
    while (idle_frames == snap_idle) @(negedge clk);
    chk(exp_len.size() == 0, "R10", "scoreboard left over", exp_len.size(), 0);
    chk(data_frames == 7, "R10", "data frames sent", data_frames, 7);
    chk(ld_ready == 1'b1, "R9", "ready when idle", ld_ready, 1);
    finish_run();
  end

endmodule